// File: doc/BRIEF.md
# Edge-Polarity GPIO Port

A 16-pin general-purpose I/O port behind a small word-addressed register bus, with one level interrupt line. Software gives each pin a role: a pin configured as an output drives its stored output bit onto the pad, and a pin configured as an input is sampled through a two-stage synchroniser. Each input pin that is not masked latches a status bit on one edge. A per-pin polarity bit selects whether that edge is the rising or the falling one.

Software clears status bits by writing ones to them. The interrupt line stays high while any status bit is set. The value read back from the input register is the synchronised pad state ANDed with a pin-enable register, so pins that are not in use read as zero. Reads are combinational while the bus strobe is held with the write flag low. Writes take effect at the clock edge.

Register offsets (byte addresses, word aligned): 0x00 input value (read-only), 0x04 output data, 0x08 direction, 0x0C edge polarity, 0x10 interrupt mask, 0x14 interrupt status, 0x18 pin enable. Every other offset, including misaligned ones, is unmapped.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, output data, direction, edge polarity, mask and pin enable all read 0xFFFF. The input value and status read 0x0000, `irq` is 0 and `pad_oe` is 0x0000.
- R2: A direction bit of 0 makes the pin an output: `pad_oe` bit is 1 and `pad_out` bit equals the output data bit. A direction bit of 1 makes the pin an input: `pad_oe` bit is 0 and `pad_out` bit is 0. Both outputs update one clock after the register write.
- R3: With a polarity bit of 1, a 0-to-1 change on an unmasked input pin sets that pin's status bit. The bit is visible three clocks after the clock edge at which the new pad level is first sampled.
- R4: With a polarity bit of 0, a 1-to-0 change sets the status bit with the same latency, and a 0-to-1 change on that pin sets nothing.
- R5: A status bit is never set for a pin whose direction bit is 0 or whose mask bit is 1.
- R6: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged. `irq` is 1 exactly while any status bit is 1, so it falls only after a status write.
- R7: Reading offset 0x00 returns the synchronised pad value ANDed with the pin-enable register. A pad change shows there two clocks after it is first sampled.
- R8: Writes to offset 0x00 are ignored: no register or pad output changes.
- R9: Reads of unmapped offsets return 0, and writes to them change nothing.
- R10: If an edge event and a status write that clears the same bit fall on the same clock edge, the bit stays set.
- R11: Output data, direction, edge polarity, mask and pin enable read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Output level per pin, 0 on input pins |
| pad_oe | output | 16 | Output enable per pin, 1 on output pins |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not reading |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
Each result has its own latency:
- Register writes, and the pad outputs derived from them, are due one clock after the write edge.
- Read data is due in the same cycle, so the bench samples it one nanosecond after driving the address in the low clock phase.
- A new pad level reaches the input register two clocks after it is first sampled.
- A new pad level reaches the status register and `irq` three clocks after it is first sampled.

The bench drives all inputs at the falling edge. It advances a reference model exactly once per rising edge, using the values that were present before that edge, so every comparison lines up with these latencies. The directed cases test the timing boundaries explicitly: the status bit is still clear after two clocks and set after three, and the input register is still stale after one clock.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

    // Register selected by the decoded bus offset
    typedef enum logic [2:0] {
        SEL_INPUT,
        SEL_OUTDATA,
        SEL_DIRECTION,
        SEL_POLARITY,
        SEL_MASK,
        SEL_STATUS,
        SEL_PINEN,
        SEL_NONE
    } reg_sel_e;

    // Byte offsets seen by software
    localparam logic [7:0] OFS_INPUT     = 8'h00;
    localparam logic [7:0] OFS_OUTDATA   = 8'h04;
    localparam logic [7:0] OFS_DIRECTION = 8'h08;
    localparam logic [7:0] OFS_POLARITY  = 8'h0C;
    localparam logic [7:0] OFS_MASK      = 8'h10;
    localparam logic [7:0] OFS_STATUS    = 8'h14;
    localparam logic [7:0] OFS_PINEN     = 8'h18;

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/gpio_edge_detect.sv
`timescale 1ns/1ps
module gpio_edge_detect #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] polarity_i,
    input  logic [WIDTH-1:0] is_input_i,
    input  logic [WIDTH-1:0] blocked_i,
    output logic [WIDTH-1:0] event_o
);

    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else begin
            last_q <= level_i;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic went_up;
        logic went_down;
        logic chosen;
        assign went_up   = level_i[i] & ~last_q[i];
        assign went_down = ~level_i[i] & last_q[i];
        assign chosen    = polarity_i[i] ? went_up : went_down;
        assign event_o[i] = chosen & is_input_i[i] & ~blocked_i[i];
    end

endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
module gpio_irq_status #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] event_i,
    input  logic [WIDTH-1:0] clear_i,
    output logic [WIDTH-1:0] status_o,
    output logic             irq_o
);

    logic [WIDTH-1:0] status_q;

    // A new event wins over a clear of the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clear_i) | event_i;
        end
    end

    assign status_o = status_q;
    assign irq_o    = |status_q;

endmodule

// File: rtl/gpio_regfile.sv
`timescale 1ns/1ps
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  level_i,
    input  logic [WIDTH-1:0]  status_i,
    output logic [WIDTH-1:0]  outdata_o,
    output logic [WIDTH-1:0]  direction_o,
    output logic [WIDTH-1:0]  polarity_o,
    output logic [WIDTH-1:0]  mask_o,
    output logic [WIDTH-1:0]  clear_o
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    reg_sel_e         sel;
    logic             wr_act;
    logic             rd_act;
    logic [WIDTH-1:0] outdata_q;
    logic [WIDTH-1:0] direction_q;
    logic [WIDTH-1:0] polarity_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] pinen_q;
    logic [WIDTH-1:0] rd_val;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        if      (a == ADDR_W'(OFS_INPUT))     return SEL_INPUT;
        else if (a == ADDR_W'(OFS_OUTDATA))   return SEL_OUTDATA;
        else if (a == ADDR_W'(OFS_DIRECTION)) return SEL_DIRECTION;
        else if (a == ADDR_W'(OFS_POLARITY))  return SEL_POLARITY;
        else if (a == ADDR_W'(OFS_MASK))      return SEL_MASK;
        else if (a == ADDR_W'(OFS_STATUS))    return SEL_STATUS;
        else if (a == ADDR_W'(OFS_PINEN))     return SEL_PINEN;
        else                                  return SEL_NONE;
    endfunction

    assign sel    = decode(bus_addr);
    assign wr_act = bus_sel & bus_wr;
    assign rd_act = bus_sel & ~bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outdata_q   <= ALL_ONES;
            direction_q <= ALL_ONES;
            polarity_q  <= ALL_ONES;
            mask_q      <= ALL_ONES;
            pinen_q     <= ALL_ONES;
        end else if (wr_act) begin
            unique case (sel)
                SEL_OUTDATA:   outdata_q   <= bus_wdata;
                SEL_DIRECTION: direction_q <= bus_wdata;
                SEL_POLARITY:  polarity_q  <= bus_wdata;
                SEL_MASK:      mask_q      <= bus_wdata;
                SEL_PINEN:     pinen_q     <= bus_wdata;
                SEL_INPUT, SEL_STATUS, SEL_NONE: ;
            endcase
        end
    end

    assign clear_o = (wr_act && sel == SEL_STATUS) ? bus_wdata : '0;

    always_comb begin
        unique case (sel)
            SEL_INPUT:     rd_val = level_i & pinen_q;
            SEL_OUTDATA:   rd_val = outdata_q;
            SEL_DIRECTION: rd_val = direction_q;
            SEL_POLARITY:  rd_val = polarity_q;
            SEL_MASK:      rd_val = mask_q;
            SEL_STATUS:    rd_val = status_i;
            SEL_PINEN:     rd_val = pinen_q;
            SEL_NONE:      rd_val = '0;
        endcase
    end

    assign bus_rdata   = rd_act ? rd_val : '0;
    assign outdata_o   = outdata_q;
    assign direction_o = direction_q;
    assign polarity_o  = polarity_q;
    assign mask_o      = mask_q;

endmodule

// File: rtl/gpio_edge_port.sv
`timescale 1ns/1ps
module gpio_edge_port #(
    parameter int PIN_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    output logic              irq
);

    logic [PIN_W-1:0] sync_q;
    logic [PIN_W-1:0] outdata_q;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] edge_q;
    logic [PIN_W-1:0] mask_q;
    logic [PIN_W-1:0] clear_w;
    logic [PIN_W-1:0] event_w;
    logic [PIN_W-1:0] stat_q;

    gpio_sync #(.WIDTH(PIN_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (sync_q)
    );

    gpio_regfile #(.WIDTH(PIN_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .level_i     (sync_q),
        .status_i    (stat_q),
        .outdata_o   (outdata_q),
        .direction_o (dir_q),
        .polarity_o  (edge_q),
        .mask_o      (mask_q),
        .clear_o     (clear_w)
    );

    gpio_edge_detect #(.WIDTH(PIN_W)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (sync_q),
        .polarity_i (edge_q),
        .is_input_i (dir_q),
        .blocked_i  (mask_q),
        .event_o    (event_w)
    );

    gpio_irq_status #(.WIDTH(PIN_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_i  (event_w),
        .clear_i  (clear_w),
        .status_o (stat_q),
        .irq_o    (irq)
    );

    // Direction 0 = output: drive the pad only there
    assign pad_oe  = ~dir_q;
    assign pad_out = outdata_q & ~dir_q;

endmodule

// File: rtl/gpio_edge_port_chk.sv
`timescale 1ns/1ps
module gpio_edge_port_chk #(
    parameter int PIN_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PIN_W-1:0]  bus_wdata,
    input logic [PIN_W-1:0]  pad_oe,
    input logic [PIN_W-1:0]  pad_out,
    input logic              irq,
    input logic [PIN_W-1:0]  sync_q,
    input logic [PIN_W-1:0]  stat_q,
    input logic [PIN_W-1:0]  dir_q,
    input logic [PIN_W-1:0]  mask_q,
    input logic [PIN_W-1:0]  edge_q
);

    logic wr_dir;
    logic wr_stat;
    logic wr_input;
    logic wr_unmapped;

    assign wr_dir   = bus_sel && bus_wr && bus_addr == ADDR_W'(8'h08);
    assign wr_stat  = bus_sel && bus_wr && bus_addr == ADDR_W'(8'h14);
    assign wr_input = bus_sel && bus_wr && bus_addr == ADDR_W'(8'h00);
    assign wr_unmapped = bus_sel && bus_wr &&
        bus_addr != ADDR_W'(8'h00) && bus_addr != ADDR_W'(8'h04) &&
        bus_addr != ADDR_W'(8'h08) && bus_addr != ADDR_W'(8'h0C) &&
        bus_addr != ADDR_W'(8'h10) && bus_addr != ADDR_W'(8'h14) &&
        bus_addr != ADDR_W'(8'h18);

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pad_oe == ~$past(bus_wdata));

    p_rise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q)) & $past(edge_q) &
         ~($past(sync_q) & ~$past(sync_q, 2))) == '0);

    p_fall_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q)) & ~$past(edge_q) &
         ~(~$past(sync_q) & $past(sync_q, 2))) == '0);

    p_input_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q)) & ~($past(dir_q) & ~$past(mask_q))) == '0);

    p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_stat));

    p_input_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_input |=> $stable(pad_oe) && $stable(pad_out));

    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unmapped |=> $stable(pad_oe) && $stable(pad_out));

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .irq       (irq),
    .sync_q    (sync_q),
    .stat_q    (stat_q),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .edge_q    (edge_q)
);

// File: tb/tb_gpio_edge_port.sv
`timescale 1ns/1ps
module tb_gpio_edge_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [15:0] m_s1, m_s2, m_prev, m_dout, m_dir, m_edge, m_mask, m_stat, m_pen, m_pad;

    always #10 clk = ~clk;

    gpio_edge_port dut (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_s2 & m_pen;
            8'h04:   return m_dout;
            8'h08:   return m_dir;
            8'h0C:   return m_edge;
            8'h10:   return m_mask;
            8'h14:   return m_stat;
            8'h18:   return m_pen;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_step(input logic [15:0] pad, input logic wr,
                              input logic [7:0] a, input logic [15:0] d);
        logic [15:0] up, down, ev, clr;
        up   = m_s2 & ~m_prev;
        down = ~m_s2 & m_prev;
        ev   = ((m_edge & up) | (~m_edge & down)) & m_dir & ~m_mask;
        clr  = (wr && a == 8'h14) ? d : 16'h0000;
        m_stat = (m_stat & ~clr) | ev;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = pad;
        if (wr) begin
            case (a)
                8'h04: m_dout = d;
                8'h08: m_dir  = d;
                8'h0C: m_edge = d;
                8'h10: m_mask = d;
                8'h18: m_pen  = d;
                default: ;
            endcase
        end
    endtask

    task automatic tick(input logic [15:0] pad, input logic wr,
                        input logic [7:0] a, input logic [15:0] d);
        pad_in = pad; m_pad = pad;
        bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step(pad, wr, a, d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(m_pad, 1'b0, 8'h00, 16'h0000);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        tick(m_pad, 1'b1, a, d);
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [15:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic check_model(input string req);
        chk({req, " irq"}, {15'd0, irq}, {15'd0, |m_stat});
        chk({req, " pad_oe"}, pad_oe, ~m_dir);
        chk({req, " pad_out"}, pad_out, m_dout & ~m_dir);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] a;
            a = 8'(k * 4);
            rd({req, " read"}, a, model_read(a));
        end
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0; m_pad = '0;
        m_dout = '1; m_dir = '1; m_edge = '1; m_mask = '1; m_pen = '1;
        void'($urandom(32'd20240611));
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        chk("R1 pad_oe", pad_oe, 16'h0000);
        rd("R1 din", 8'h00, 16'h0000);
        rd("R1 dout", 8'h04, 16'hFFFF);
        rd("R1 dir", 8'h08, 16'hFFFF);
        rd("R1 edge", 8'h0C, 16'hFFFF);
        rd("R1 mask", 8'h10, 16'hFFFF);
        rd("R1 status", 8'h14, 16'h0000);
        rd("R1 pinen", 8'h18, 16'hFFFF);

        // R11 readback, R2 pad drive
        wr(8'h04, 16'hA5A5);
        wr(8'h08, 16'h00FF);
        rd("R11 dout", 8'h04, 16'hA5A5);
        rd("R11 dir", 8'h08, 16'h00FF);
        chk("R2 pad_oe", pad_oe, 16'hFF00);
        chk("R2 pad_out", pad_out, 16'hA500);
        wr(8'h0C, 16'h1234);
        rd("R11 edge", 8'h0C, 16'h1234);
        check_model("R11 model");

        // R3 rising edge latency
        wr(8'h08, 16'hFFFF);
        wr(8'h0C, 16'hFFFF);
        wr(8'h10, 16'h0000);
        idle(4);
        wr(8'h14, 16'hFFFF);
        tick(16'h0001, 1'b0, 8'h00, 16'h0000);
        tick(16'h0001, 1'b0, 8'h00, 16'h0000);
        rd("R3 not yet", 8'h14, 16'h0000);
        tick(16'h0001, 1'b0, 8'h00, 16'h0000);
        rd("R3 rise", 8'h14, 16'h0001);
        chk("R3 irq", {15'd0, irq}, 16'h0001);

        // R4 falling edge on bit1
        wr(8'h0C, 16'hFFFD);
        tick(16'h0003, 1'b0, 8'h00, 16'h0000);
        idle(3);
        rd("R4 rise ignored", 8'h14, 16'h0001);
        tick(16'h0001, 1'b0, 8'h00, 16'h0000);
        idle(1);
        rd("R4 not yet", 8'h14, 16'h0001);
        idle(1);
        rd("R4 fall", 8'h14, 16'h0003);

        // R6 write-one-to-clear
        wr(8'h14, 16'h0001);
        rd("R6 partial", 8'h14, 16'h0002);
        chk("R6 irq held", {15'd0, irq}, 16'h0001);
        wr(8'h14, 16'h0000);
        rd("R6 zero write", 8'h14, 16'h0002);
        wr(8'h14, 16'h0002);
        rd("R6 cleared", 8'h14, 16'h0000);
        chk("R6 irq low", {15'd0, irq}, 16'h0000);

        // R5 masked pin and output pin
        wr(8'h10, 16'h0004);
        tick(16'h0005, 1'b0, 8'h00, 16'h0000);
        idle(4);
        rd("R5 masked", 8'h14, 16'h0000);
        wr(8'h08, 16'hFFF7);
        chk("R2 output pin", pad_oe, 16'h0008);
        tick(16'h000D, 1'b0, 8'h00, 16'h0000);
        idle(4);
        rd("R5 output pin", 8'h14, 16'h0000);
        chk("R5 irq", {15'd0, irq}, 16'h0000);

        // R10 set wins over clear on the same edge
        tick(16'h001D, 1'b0, 8'h00, 16'h0000);
        idle(1);
        wr(8'h14, 16'h0010);
        rd("R10 set wins", 8'h14, 16'h0010);
        wr(8'h14, 16'h0010);
        rd("R10 then clear", 8'h14, 16'h0000);

        // R7 pin-enable gating and latency
        wr(8'h18, 16'h00F0);
        rd("R7 gated", 8'h00, 16'h0010);
        tick(16'h0FFF, 1'b0, 8'h00, 16'h0000);
        rd("R7 stale", 8'h00, 16'h0010);
        idle(1);
        rd("R7 new", 8'h00, 16'h00F0);
        idle(2);
        check_model("R7 model");
        wr(8'h14, 16'hFFFF);

        // R8 input register read-only
        wr(8'h00, 16'h1234);
        rd("R8 din", 8'h00, 16'h00F0);
        check_model("R8 model");

        // R9 unmapped offsets
        rd("R9 0x1C", 8'h1C, 16'h0000);
        rd("R9 0x40", 8'h40, 16'h0000);
        rd("R9 misaligned", 8'h02, 16'h0000);
        wr(8'h1C, 16'h0000);
        wr(8'h06, 16'h0000);
        check_model("R9 model");

        // Random phase, mixes R3 R4 R5 R6 R7 R11
        for (int it = 0; it < 3000; it++) begin
            logic [15:0] p;
            logic        w;
            logic [7:0]  a;
            p = m_pad ^ ($urandom() & $urandom() & $urandom());
            w = ($urandom() % 3) == 0;
            a = 8'(($urandom() % 9) * 4);
            tick(p, w, a, 16'($urandom()));
            chk("R6 rand irq", {15'd0, irq}, {15'd0, |m_stat});
            chk("R2 rand oe", pad_oe, ~m_dir);
            chk("R2 rand out", pad_out, m_dout & ~m_dir);
            a = 8'(($urandom() % 9) * 4);
            rd("R11 rand read", a, model_read(a));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule